// File: doc/BRIEF.md
# Supervisory Reset Generator with Bus-Serviced Watchdog

This block drives a processor reset from three sources: power-up, a supply brownout and a watchdog that has run out. The supply condition arrives as one synchronous digital flag, `supply_ok`, which is high while the supply is above its trip threshold. Whenever reset becomes active, it stays active until `supply_ok` has been high for a full release window of `RELEASE_MS` milliseconds. Time is measured in clock cycles, with `MS_CYCLES` cycles per millisecond.

The watchdog is serviced by traffic on a two-wire bus. Both bus lines pass through two-flop synchronizers. A START condition restarts the watchdog count; a START is a falling edge on the data line while the clock line is high. A 2-bit period code selects the timeout length or turns the watchdog off. A high write-protect input blocks any update to that code.

While reset is active, the block holds a bus-block level high so that no transfer can start. On each entry into reset it emits a one-cycle abort pulse, which terminates any transfer in progress. It also gates requests to begin a nonvolatile write. A write that is already running is not touched, because only the start of a write is gated. A parameter sets the polarity of the reset pin.

Top module: `supv_reset_top`

## Requirements
- R1: After `rst_n` releases with `supply_ok` high, reset stays active for exactly REL = `RELEASE_MS*MS_CYCLES` clock edges. It is released on the REL-th edge.
- R2: When `supply_ok` is sampled low, reset is active after that same edge. The release window restarts from zero, so reset is released only after REL consecutive edges with `supply_ok` high.
- R3: A START restarts the watchdog count. A START is a falling edge on `sda_in` while `scl_in` is high, seen after two-flop synchronization. A falling edge on `sda_in` while `scl_in` is low is not a START. A rising edge on `sda_in` while `scl_in` is high is not a START.
- R4: If no START arrives, reset asserts on the P-th edge after release, where P is the selected period in cycles. That reset then lasts REL edges, and the watchdog count restarts from zero once reset is released.
- R5: The period code `wd_sel` maps as follows: 0 → 1400 ms, 1 → 600 ms, 2 → 200 ms, 3 → watchdog off (never expires). Each value is scaled by `MS_CYCLES`.
- R6: `wd_sel_wr` with `wd_wp` low loads `wd_sel_wdata` into `wd_sel` on the next edge. With `wd_wp` high, `wd_sel` stays unchanged.
- R7: `bus_block` is high exactly while reset is active. `xfer_abort` is a one-cycle pulse that is high in the first cycle of each reset entry caused by a brownout or a timeout. It does not pulse on power-up.
- R8: `nv_start_ok` equals `nv_start_req` while reset is inactive and is 0 while reset is active.
- R9: With `ACTIVE_LOW`=1, `sys_rst` is 0 while reset is active. With `ACTIVE_LOW`=0, `sys_rst` is 1 while reset is active.
- R10: After `rst_n` is asserted, `wd_sel` is 0 (the longest period).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Supply above trip threshold (synchronous) |
| sda_in | input | 1 | Bus data line (asynchronous) |
| scl_in | input | 1 | Bus clock line (asynchronous) |
| wd_sel_wr | input | 1 | Write strobe for the period code |
| wd_sel_wdata | input | 2 | New period code |
| wd_wp | input | 1 | Write protect for the period code |
| nv_start_req | input | 1 | Request to begin a nonvolatile write |
| wd_sel | output | 2 | Current period code |
| sys_rst | output | 1 | Processor reset, polarity set by `ACTIVE_LOW` |
| bus_block | output | 1 | High while reset is active; blocks new transfers |
| xfer_abort | output | 1 | One-cycle pulse on entry into reset |
| nv_start_ok | output | 1 | Grant to begin a nonvolatile write |

## Verification
The assertions check these rules on every cycle:
- a low `supply_ok` forces reset on the following edge;
- every release is preceded by a high `supply_ok`;
- the abort pulse coincides with each rise of reset;
- a protected write leaves the period code unchanged;
- the off code never expires;
- an expiry is always followed by reset;
- no nonvolatile start is granted while reset is active.

Only the bench scenarios can show that the release window and each of the four timeout periods have their exact cycle counts. The same holds for whether a glitch inside the window restarts the count, and for whether look-alike bus patterns fail to service the watchdog.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'd0,
    WD_MID   = 2'd1,
    WD_SHORT = 2'd2,
    WD_OFF   = 2'd3
  } wd_sel_e;

  localparam int unsigned WD_LONG_MS  = 1400;
  localparam int unsigned WD_MID_MS   = 600;
  localparam int unsigned WD_SHORT_MS = 200;

  // Period in milliseconds for a code; 0 means the watchdog never fires.
  function automatic int unsigned wd_period_ms(input wd_sel_e sel);
    case (sel)
      WD_LONG:  return WD_LONG_MS;
      WD_MID:   return WD_MID_MS;
      WD_SHORT: return WD_SHORT_MS;
      default:  return 0;
    endcase
  endfunction

  function automatic int unsigned ms_to_cycles(input int unsigned ms,
                                               input int unsigned cyc_per_ms);
    return ms * cyc_per_ms;
  endfunction

  function automatic int unsigned wd_period_cycles(input wd_sel_e sel,
                                                   input int unsigned cyc_per_ms);
    return ms_to_cycles(wd_period_ms(sel), cyc_per_ms);
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W    = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= INIT[i];
        sync_q <= INIT[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end
endmodule

// File: rtl/supv_start_det.sv
module supv_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start
);
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_d <= 1'b1;
    else        sda_d <= sda_s;
  end

  assign start = scl_s & sda_d & ~sda_s;

  // R3
  single_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);
endmodule

// File: rtl/supv_period_reg.sv
module supv_period_reg
  import supv_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr,
  input  logic [1:0] wdata,
  input  logic    wp,
  output wd_sel_e sel
);
  logic wr_ok;
  assign wr_ok = wr & ~wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel <= WD_LONG;
    else if (wr_ok) sel <= wd_sel_e'(wdata);
  end

  // R6
  wp_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wp) |=> $stable(sel));
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer
  import supv_pkg::*;
#(
  parameter int unsigned MS_CYCLES = 100000,
  localparam int unsigned MAX_CYC  = ms_to_cycles(WD_LONG_MS, MS_CYCLES),
  localparam int unsigned CW       = $clog2(MAX_CYC + 1)
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hold,
  input  logic    kick,
  input  wd_sel_e sel,
  output logic    expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          off;

  assign off    = (sel == WD_OFF);
  assign lim    = CW'(wd_period_cycles(sel, MS_CYCLES) - 1);
  assign expire = ~hold & ~off & (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt <= '0;
    else if (hold || kick || off || expire) cnt <= '0;
    else                                    cnt <= cnt + 1'b1;
  end

  // R5
  off_never_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |-> !expire);
  // R4
  restart_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> (cnt == '0));
endmodule

// File: rtl/supv_rel_timer.sv
module supv_rel_timer #(
  parameter int unsigned REL_CYC = 20000000,
  localparam int unsigned RW     = $clog2(REL_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic rst_active,
  output logic abort
);
  localparam logic [RW-1:0] LAST = RW'(REL_CYC - 1);
  logic [RW-1:0] cnt;
  logic          trip;

  assign trip = ~supply_ok | wd_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_active <= 1'b1;
      cnt        <= '0;
      abort      <= 1'b0;
    end else begin
      abort <= trip & ~rst_active;
      if (trip) begin
        rst_active <= 1'b1;
        cnt        <= '0;
      end else if (rst_active) begin
        if (cnt == LAST) begin
          rst_active <= 1'b0;
          cnt        <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  brownout_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> rst_active);
  // R1
  release_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_active) |-> $past(supply_ok));
  // R7
  abort_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_active) |-> abort);
  // R7
  abort_only_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $rose(rst_active));
endmodule

// File: rtl/supv_reset_top.sv
module supv_reset_top
  import supv_pkg::*;
#(
  parameter int unsigned MS_CYCLES  = 100000,
  parameter int unsigned RELEASE_MS = 200,
  parameter bit          ACTIVE_LOW = 1'b1,
  localparam int unsigned REL_CYC   = ms_to_cycles(RELEASE_MS, MS_CYCLES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       wd_sel_wr,
  input  logic [1:0] wd_sel_wdata,
  input  logic       wd_wp,
  input  logic       nv_start_req,
  output logic [1:0] wd_sel,
  output logic       sys_rst,
  output logic       bus_block,
  output logic       xfer_abort,
  output logic       nv_start_ok
);
  logic [1:0] bus_s;
  logic       start_ev;
  logic       wd_expire;
  logic       rst_active;
  wd_sel_e    sel;

  supv_sync #(.W(2), .INIT(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(bus_s)
  );

  supv_start_det u_start (
    .clk(clk), .rst_n(rst_n), .sda_s(bus_s[0]), .scl_s(bus_s[1]), .start(start_ev)
  );

  supv_period_reg u_sel (
    .clk(clk), .rst_n(rst_n), .wr(wd_sel_wr), .wdata(wd_sel_wdata),
    .wp(wd_wp), .sel(sel)
  );

  supv_wd_timer #(.MS_CYCLES(MS_CYCLES)) u_wd (
    .clk(clk), .rst_n(rst_n), .hold(rst_active), .kick(start_ev),
    .sel(sel), .expire(wd_expire)
  );

  supv_rel_timer #(.REL_CYC(REL_CYC)) u_rel (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wd_expire(wd_expire),
    .rst_active(rst_active), .abort(xfer_abort)
  );

  if (ACTIVE_LOW) begin : g_pol_low
    assign sys_rst = ~rst_active;
  end else begin : g_pol_high
    assign sys_rst = rst_active;
  end

  assign wd_sel      = sel;
  assign bus_block   = rst_active;
  assign nv_start_ok = nv_start_req & ~rst_active;

  // R4
  expire_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> rst_active);
  // R8
  no_nv_start_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_block |-> !nv_start_ok);
endmodule

// File: tb/test_supv_reset_top.sv
module test_supv_reset_top;
  localparam int unsigned MS  = 4;
  localparam int unsigned REL = 200 * MS;

  logic clk = 1'b0;
  logic rst_n, supply_ok, sda, scl, wr, wp, req;
  logic [1:0] wdata;
  logic [1:0] wd_sel, wd_sel_h;
  logic sys_rst, bus_block, xfer_abort, nv_ok;
  logic sys_rst_h, bus_block_h, xfer_abort_h, nv_ok_h;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  supv_reset_top #(.MS_CYCLES(MS), .RELEASE_MS(200), .ACTIVE_LOW(1'b1)) i_supv_reset_top (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_in(sda), .scl_in(scl),
    .wd_sel_wr(wr), .wd_sel_wdata(wdata), .wd_wp(wp), .nv_start_req(req),
    .wd_sel(wd_sel), .sys_rst(sys_rst), .bus_block(bus_block),
    .xfer_abort(xfer_abort), .nv_start_ok(nv_ok)
  );

  supv_reset_top #(.MS_CYCLES(MS), .RELEASE_MS(200), .ACTIVE_LOW(1'b0)) i_supv_reset_top_hi (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sda_in(sda), .scl_in(scl),
    .wd_sel_wr(wr), .wd_sel_wdata(wdata), .wd_wp(wp), .nv_start_req(req),
    .wd_sel(wd_sel_h), .sys_rst(sys_rst_h), .bus_block(bus_block_h),
    .xfer_abort(xfer_abort_h), .nv_start_ok(nv_ok_h)
  );

  function automatic int exp_period(input int code);
    int ms_tab[4] = '{1400, 600, 200, 0};
    return ms_tab[code] * MS;
  endfunction

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // count negedges until reset (active low) is seen released
  task automatic wait_release(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sys_rst && n < 20000);
  endtask

  task automatic wait_assert(input int limit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (sys_rst && n < limit);
  endtask

  task automatic write_sel(input int code, input logic prot);
    wp = prot; wr = 1'b1; wdata = 2'(code);
    tick(1);
    wr = 1'b0; wp = 1'b0;
  endtask

  task automatic restart(output int n);
    supply_ok = 1'b0;
    tick(1);
    supply_ok = 1'b1;
    wait_release(n);
  endtask

  task automatic bus_start();
    sda = 1'b1; scl = 1'b1; tick(3);
    sda = 1'b0; tick(4);
    scl = 1'b0; tick(2);
    sda = 1'b1; tick(2);
    scl = 1'b1; tick(2);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; supply_ok = 1'b0; sda = 1'b1; scl = 1'b1;
    wr = 1'b0; wp = 1'b0; req = 1'b1; wdata = 2'd0;
    tick(3);
    chk("R9 reset low when active", int'(sys_rst), 0);
    chk("R9 high polarity", int'(sys_rst_h), 1);
    chk("R7 bus_block in reset", int'(bus_block), 1);
    chk("R10 period code after reset", int'(wd_sel), 0);
    chk("R8 nv start gated", int'(nv_ok), 0);

    supply_ok = 1'b1; rst_n = 1'b1;
    wait_release(n);
    chk("R1 power-up release cycles", n, REL);
    chk("R7 no abort on power-up", int'(xfer_abort), 0);
    chk("R8 nv start granted", int'(nv_ok), 1);
    chk("R9 high polarity released", int'(sys_rst_h), 0);

    // brownout
    tick(100);
    supply_ok = 1'b0;
    tick(1);
    chk("R2 brownout asserts", int'(sys_rst), 0);
    chk("R7 abort pulse", int'(xfer_abort), 1);
    chk("R7 bus_block", int'(bus_block), 1);
    supply_ok = 1'b1;
    tick(1);
    chk("R7 abort one cycle", int'(xfer_abort), 0);
    tick(300);
    supply_ok = 1'b0; tick(1);
    chk("R7 no abort when already active", int'(xfer_abort), 0);
    supply_ok = 1'b1;
    wait_release(n);
    chk("R2 window restarts after glitch", n, REL);

    // R6 write protect
    write_sel(3, 1'b1);
    chk("R6 protected write ignored", int'(wd_sel), 0);
    write_sel(2, 1'b0);
    chk("R6 unprotected write", int'(wd_sel), 2);

    // R5 / R4 sweep over all codes
    for (int code = 0; code < 4; code++) begin
      write_sel(code, 1'b0);
      restart(n);
      chk("R1 release in sweep", n, REL);
      if (exp_period(code) == 0) begin
        wait_assert(7000, n);
        chk("R5 off code never expires", int'(sys_rst), 1);
      end else begin
        wait_assert(7000, n);
        chk($sformatf("R5 period code %0d", code), n, exp_period(code));
        chk("R7 abort on timeout", int'(xfer_abort), 1);
        wait_release(n);
        chk("R4 timeout reset length", n, REL);
        wait_assert(7000, n);
        chk("R4 watchdog restarts after release", n, exp_period(code));
      end
    end

    // R3 START service
    write_sel(2, 1'b0);
    restart(n);
    for (int k = 0; k < 6; k++) begin
      tick(500);
      bus_start();
    end
    chk("R3 START keeps reset released", int'(sys_rst), 1);
    // look-alike patterns only
    n = 0;
    while (sys_rst && n < 2000) begin
      case (n % 8)
        0: scl = 1'b0;
        2: sda = 1'b0;
        4: scl = 1'b1;
        6: sda = 1'b1;
        default: ;
      endcase
      tick(1);
      n++;
    end
    checks++;
    if (n < exp_period(2) - 20 || n > exp_period(2)) begin
      fails++;
      $display("FAIL R3 non-START patterns serviced watchdog actual=%0d expected=%0d..%0d",
               n, exp_period(2) - 20, exp_period(2));
    end
    sda = 1'b1; scl = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule